// File: doc/BRIEF.md
# UART receive status and interrupt logic

This block sits between the receive shift register of one UART channel and the host bus. Each character the receiver assembles is handed over with three error tags: parity, framing and break. The block stores the character and its tags in a receive FIFO. The tags of a character become visible in the line status word, and can raise an interrupt, only once that character is at the read position. An overrun is reported as soon as the overrunning character arrives. A separate status bit stays high while any stored character carries an error.

The host reaches the block through a small register window.
- At address 0 a read returns the oldest character and removes it from the FIFO.
- Address 1 holds a four-bit interrupt enable register.
- A write to address 2 sets the FIFO mode: bit 0 enables the FIFO, bit 1 flushes it, and bits 7:6 select the receive trigger level.
- Address 3 holds the line control byte. Its bit 7 turns addresses 0 and 1 into the low and high bytes of the 16-bit baud divisor, which is driven out on `div_value`.
- Address 5 returns the line status word.

Three interrupt requests leave the block separately and are also combined into one output.
- The receive request follows the FIFO occupancy against the trigger level.
- The line status request follows the overrun flag and the error tags of the character at the read position.
- The transmit request follows the transmit FIFO empty input.

Setting the FIFO enable and clearing the enable bits gives polled operation, in which the host uses only the status word.

Top module: `uart_rx_status`

## Requirements
- R1: After reset the interrupt enable register, the line control byte, the FIFO mode (disabled, trigger select 0) and the divisor are all 0, the FIFO is empty, and all interrupt outputs are low.
- R2: Status bit 0 is 1 exactly while the receive FIFO holds at least one character. A read of address 0 with line control bit 7 clear returns the oldest character and removes it. On an empty FIFO such a read returns 0.
- R3: In FIFO mode the capacity is DEPTH characters. A character pushed while the FIFO is full, and not read in the same cycle, is discarded and sets status bit 1 (overrun). With enable bit 2 set, `irq_line` rises in the next cycle.
- R4: Status bits 2, 3 and 4 hold the parity, framing and break tags of the character at the read position. They load when that character becomes the oldest entry and are 0 when the FIFO empties. With enable bit 2 set, `irq_line` is high while bit 1 or any of bits 2 to 4 is 1.
- R5: A read of address 5 clears status bits 1 to 4. A new oldest character arriving, or an overrun, in the same cycle takes precedence over the clear.
- R6: Status bit 7 is 1 exactly while at least one character stored in the FIFO carries a parity, framing or break tag.
- R7: Status bit 5 equals `tx_fifo_empty`. Status bit 6 is the AND of `tx_fifo_empty` and `tx_shift_empty`.
- R8: In FIFO mode, with enable bit 0 set, `irq_rx` is high exactly while the occupancy is at least the trigger level. Mode bits 7:6 select the level: 00 gives 1, 01 gives 4, 10 gives 8 and 11 gives 14.
- R9: With FIFO mode bit 0 clear, the FIFO holds one character. A second character is an overrun. With enable bit 0 set, `irq_rx` is high while that character is held.
- R10: Enable bit 0 gates `irq_rx`, bit 1 gates `irq_tx` (high while `tx_fifo_empty`) and bit 2 gates `irq_line`. `irq` is the OR of the three. With bits 0 to 3 clear no interrupt output rises, and the status word still tracks the FIFO.
- R11: While line control bit 7 is 1, addresses 0 and 1 read and write the low and high divisor bytes, which drive `div_value`, and a read of address 0 removes nothing. While bit 7 is 0, the same addresses reach the FIFO read port and the enable register (bits 3:0; bits 7:4 read 0).
- R12: A write to address 2 stores bit 0 and bits 7:6, which read back at the same positions. The FIFO and its tags are flushed when bit 1 is 1 or bit 0 differs from the stored enable. The overrun flag is not touched by a flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access; side effects take place at the clock edge |
| bus_rdata | output | 8 | Read data for the addressed register, combinational |
| rx_push | input | 1 | A received character is offered this cycle |
| rx_char | input | 8 | Received character |
| rx_perr | input | 1 | Parity error tag of the character |
| rx_ferr | input | 1 | Framing error tag of the character |
| rx_brk | input | 1 | Break tag of the character |
| tx_fifo_empty | input | 1 | Transmit FIFO is empty |
| tx_shift_empty | input | 1 | Transmit shift register is empty |
| div_value | output | 16 | Baud divisor |
| irq_rx | output | 1 | Receive data interrupt request |
| irq_line | output | 1 | Line status interrupt request |
| irq_tx | output | 1 | Transmit ready interrupt request |
| irq | output | 1 | OR of the three requests |

## Verification
The bench builds the block with the default DEPTH of 16. That depth puts the highest trigger level of 14 and a genuinely full FIFO within reach. So the bench can walk the occupancy up to 15 and back down for every trigger selection and see each assert and deassert point of the receive request. It can also push a seventeenth character to force an overrun, and push into a full FIFO in the same cycle as a read to confirm that this is not an overrun. With the FIFO disabled, the same default collapses to a one-character holding register, which the bench also drives into overrun.

// File: rtl/uart_rx_status.sv
module uart_rx_status #(
  parameter int DEPTH = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  bus_addr,
  input  logic [7:0]  bus_wdata,
  input  logic        bus_wr,
  input  logic        bus_rd,
  output logic [7:0]  bus_rdata,
  input  logic        rx_push,
  input  logic [7:0]  rx_char,
  input  logic        rx_perr,
  input  logic        rx_ferr,
  input  logic        rx_brk,
  input  logic        tx_fifo_empty,
  input  logic        tx_shift_empty,
  output logic [15:0] div_value,
  output logic        irq_rx,
  output logic        irq_line,
  output logic        irq_tx,
  output logic        irq
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [10:0]   mem [DEPTH];
  logic [AW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] cnt, errcnt;
  logic [3:0]    ier;
  logic [7:0]    lcr;
  logic          fifo_en;
  logic [1:0]    trig_sel;
  logic          ovr;
  logic [2:0]    err_lat;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  wire           dlab     = lcr[7];
  wire [2:0]     rx_tags  = {rx_brk, rx_ferr, rx_perr};
  wire [CW-1:0]  cap      = fifo_en ? CW'(DEPTH) : CW'(1);
  wire           do_pop   = bus_rd && bus_addr == 3'd0 && !dlab && cnt != '0;
  wire           overrun  = rx_push && cnt == cap && !do_pop;
  wire           accept   = rx_push && !overrun;
  wire           lsr_rd   = bus_rd && bus_addr == 3'd5;
  wire           fcr_wr   = bus_wr && bus_addr == 3'd2;
  wire           flush    = fcr_wr && (bus_wdata[1] || bus_wdata[0] != fifo_en);
  wire [AW-1:0]  rd_nxt   = ptr_inc(rd_ptr);
  wire [10:0]    head     = mem[rd_ptr];
  wire           head_err = |head[10:8];
  wire           head_chg = do_pop || (accept && cnt == '0);

  logic [2:0] head_tags_nxt;
  always_comb begin
    head_tags_nxt = 3'b000;
    if (do_pop && cnt > CW'(1))
      head_tags_nxt = mem[rd_nxt][10:8];
    else if (accept)
      head_tags_nxt = rx_tags;
  end

  logic [CW-1:0] trig_lvl;
  always_comb begin
    if (!fifo_en) trig_lvl = CW'(1);
    else begin
      case (trig_sel)
        2'd0:    trig_lvl = CW'(1);
        2'd1:    trig_lvl = CW'(4);
        2'd2:    trig_lvl = CW'(8);
        default: trig_lvl = CW'(14);
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (accept) mem[wr_ptr] <= {rx_tags, rx_char};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      cnt    <= '0;
      errcnt <= '0;
    end else if (flush) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      cnt    <= '0;
      errcnt <= '0;
    end else begin
      if (do_pop) rd_ptr <= rd_nxt;
      if (accept) wr_ptr <= ptr_inc(wr_ptr);
      cnt    <= cnt + CW'(accept) - CW'(do_pop);
      errcnt <= errcnt + CW'(accept && |rx_tags) - CW'(do_pop && head_err);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ier       <= '0;
      lcr       <= '0;
      fifo_en   <= 1'b0;
      trig_sel  <= 2'd0;
      div_value <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        3'd0: if (dlab) div_value[7:0] <= bus_wdata;
        3'd1: if (dlab) div_value[15:8] <= bus_wdata; else ier <= bus_wdata[3:0];
        3'd2: begin
          fifo_en  <= bus_wdata[0];
          trig_sel <= bus_wdata[7:6];
        end
        3'd3: lcr <= bus_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr     <= 1'b0;
      err_lat <= 3'b000;
    end else begin
      if (overrun)     ovr <= 1'b1;
      else if (lsr_rd) ovr <= 1'b0;
      if (flush)         err_lat <= 3'b000;
      else if (head_chg) err_lat <= head_tags_nxt;
      else if (lsr_rd)   err_lat <= 3'b000;
    end
  end

  wire [7:0] lsr = {errcnt != '0, tx_fifo_empty & tx_shift_empty, tx_fifo_empty,
                    err_lat, ovr, cnt != '0};

  always_comb begin
    case (bus_addr)
      3'd0:    bus_rdata = dlab ? div_value[7:0] : (cnt != '0 ? head[7:0] : 8'h00);
      3'd1:    bus_rdata = dlab ? div_value[15:8] : {4'h0, ier};
      3'd2:    bus_rdata = {trig_sel, 5'b00000, fifo_en};
      3'd3:    bus_rdata = lcr;
      3'd5:    bus_rdata = lsr;
      default: bus_rdata = 8'h00;
    endcase
  end

  assign irq_rx   = ier[0] && cnt >= trig_lvl;
  assign irq_line = ier[2] && (ovr || |err_lat);
  assign irq_tx   = ier[1] && tx_fifo_empty;
  assign irq      = irq_rx | irq_line | irq_tx;

  // R3
  depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));
  // R3
  overrun_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && cnt == cap && !do_pop && ier[2] && !bus_wr) |=> irq_line);
  // R6
  errcnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    errcnt <= cnt);
  // R2
  last_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (do_pop && cnt == CW'(1) && !rx_push) |=> (lsr[0] == 1'b0 && lsr[4:2] == 3'b000));
  // R8
  rx_irq_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rx |-> lsr[0]);
  // R10
  polled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ier[2:0] == 3'b000) |-> !irq);

endmodule

// File: tb/uart_rx_status_test.sv
`timescale 1ns/1ps
module uart_rx_status_test;
  logic clk = 0, rst_n = 0;
  logic [2:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0, rx_char = 0, bus_rdata;
  logic bus_wr = 0, bus_rd = 0, rx_push = 0, rx_perr = 0, rx_ferr = 0, rx_brk = 0;
  logic tx_fifo_empty = 1, tx_shift_empty = 1;
  logic [15:0] div_value;
  logic irq_rx, irq_line, irq_tx, irq;

  always #4 clk = ~clk;

  uart_rx_status uut (.*);

  int errors = 0, checks = 0;
  bit done = 0;

  logic [10:0] q[$];
  logic [3:0] m_ier = 0;
  logic [7:0] m_lcr = 0;
  logic m_fen = 0, m_ovr = 0;
  logic [1:0] m_trig = 0;
  logic [15:0] m_div = 0;
  logic [2:0] m_elat = 0;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] m_lsr();
    logic any = 0;
    foreach (q[i]) if (|q[i][10:8]) any = 1;
    return {any, tx_fifo_empty & tx_shift_empty, tx_fifo_empty, m_elat, m_ovr, q.size() != 0};
  endfunction

  function automatic int m_trig_lvl();
    if (!m_fen) return 1;
    case (m_trig) 0: return 1; 1: return 4; 2: return 8; default: return 14; endcase
  endfunction

  task automatic step(input [2:0] a, input [7:0] wd, input bit w, input bit r,
                      input bit p, input [7:0] ch, input [2:0] fl, input string tag);
    logic [7:0] er;
    bit dl, pop, ovrn, lrd, fl_sh;
    int cap, osz;
    bus_addr = a; bus_wdata = wd; bus_wr = w; bus_rd = r;
    rx_push = p; rx_char = ch; {rx_brk, rx_ferr, rx_perr} = fl;
    #1;
    dl = m_lcr[7];
    case (a)
      0: er = dl ? m_div[7:0] : (q.size() ? q[0][7:0] : 8'h00);
      1: er = dl ? m_div[15:8] : {4'h0, m_ier};
      2: er = {m_trig, 5'b0, m_fen};
      3: er = m_lcr;
      5: er = m_lsr();
      default: er = 0;
    endcase
    if (r) chk(tag, "rdata", bus_rdata, er);
    chk(m_fen ? "R8" : "R9", "irq_rx", irq_rx, m_ier[0] && q.size() >= m_trig_lvl());
    chk("R4", "irq_line", irq_line, m_ier[2] && (m_ovr || |m_elat));
    chk("R10", "irq_tx", irq_tx, m_ier[1] && tx_fifo_empty);
    chk("R10", "irq", irq, irq_rx | irq_line | irq_tx);
    chk("R11", "div_value", div_value, m_div);
    @(posedge clk);
    cap = m_fen ? 16 : 1;
    osz = q.size();
    pop = r && a == 0 && !dl && osz > 0;
    lrd = r && a == 5;
    if (pop) void'(q.pop_front());
    ovrn = p && osz == cap && !pop;
    if (p && !ovrn) q.push_back({fl, ch});
    if (pop || (p && !ovrn && osz == 0)) m_elat = q.size() ? q[0][10:8] : 3'b0;
    else if (lrd) m_elat = 0;
    if (ovrn) m_ovr = 1; else if (lrd) m_ovr = 0;
    if (w) begin
      case (a)
        0: if (dl) m_div[7:0] = wd;
        1: if (dl) m_div[15:8] = wd; else m_ier = wd[3:0];
        2: begin
          fl_sh = wd[1] || wd[0] != m_fen;
          m_fen = wd[0]; m_trig = wd[7:6];
          if (fl_sh) begin q.delete(); m_elat = 0; end
        end
        3: m_lcr = wd;
        default: ;
      endcase
    end
    @(negedge clk);
    bus_wr = 0; bus_rd = 0; rx_push = 0;
  endtask

  task automatic wreg(input [2:0] a, input [7:0] d);
    step(a, d, 1, 0, 0, 0, 0, "R12");
  endtask
  task automatic rreg(input [2:0] a, input string tag);
    step(a, 0, 0, 1, 0, 0, 0, tag);
  endtask
  task automatic push(input [7:0] c, input [2:0] f);
    step(0, 0, 0, 0, 1, c, f, "R2");
  endtask
  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0, "R1");
  endtask

  initial begin
    #800000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rreg(1, "R1"); rreg(2, "R1"); rreg(3, "R1"); rreg(5, "R1"); rreg(0, "R1");
    // R2 basic FIFO push and read
    wreg(2, 8'h01); wreg(1, 8'h07);
    push(8'h41, 0); rreg(5, "R2"); rreg(0, "R2"); rreg(5, "R2"); rreg(0, "R2");
    // R8 every trigger level, filling up to 15 and draining
    for (int t = 0; t < 4; t++) begin
      wreg(2, 8'((t << 6) | 3));
      rreg(2, "R12");
      for (int i = 0; i < 15; i++) push(8'(8'h10 + i), 0);
      for (int i = 0; i < 15; i++) rreg(0, "R8");
    end
    // R3 overrun on full FIFO, then R5 clear by status read
    wreg(2, 8'h03);
    for (int i = 0; i < 16; i++) push(8'(i), 0);
    rreg(5, "R3");
    push(8'hEE, 0); idle();
    rreg(5, "R3"); rreg(5, "R5");
    step(0, 0, 0, 1, 1, 8'h77, 0, "R3");
    rreg(5, "R3");
    for (int i = 0; i < 16; i++) rreg(0, "R2");
    // R4 R6 errored characters
    wreg(2, 8'h03);
    push(8'h01, 0); push(8'h02, 3'b001); push(8'h03, 3'b010); push(8'h04, 3'b100); push(8'h05, 0);
    rreg(5, "R6");
    for (int i = 0; i < 5; i++) begin rreg(0, "R4"); rreg(5, "R4"); rreg(5, "R5"); end
    rreg(5, "R6");
    push(8'h09, 3'b110); rreg(5, "R4"); idle(); rreg(0, "R6"); rreg(5, "R6");
    // R10 polled mode
    wreg(1, 8'h00); wreg(2, 8'h03);
    for (int i = 0; i < 17; i++) push(8'(i), 3'(i));
    rreg(5, "R10"); rreg(0, "R10"); rreg(5, "R10");
    // R12 flush by bit 1 keeps overrun untouched
    push(8'hAA, 0);
    wreg(2, 8'h03); rreg(5, "R12");
    // R9 non-FIFO holding register
    wreg(1, 8'h05); wreg(2, 8'h00); rreg(2, "R12");
    push(8'h51, 0); idle(); push(8'h52, 0); rreg(5, "R9"); rreg(0, "R9"); rreg(5, "R9");
    push(8'h53, 3'b010); rreg(5, "R9"); rreg(0, "R9");
    // R7 transmit status
    wreg(1, 8'h02);
    tx_fifo_empty = 0; tx_shift_empty = 0; rreg(5, "R7");
    tx_fifo_empty = 1; rreg(5, "R7");
    tx_shift_empty = 1; rreg(5, "R7");
    tx_fifo_empty = 0; tx_shift_empty = 1; rreg(5, "R7"); idle();
    // R11 divisor latch window
    wreg(1, 8'h09);
    wreg(2, 8'h01);
    push(8'h66, 0);
    wreg(3, 8'h83); step(0, 8'h34, 1, 0, 0, 0, 0, "R11"); step(1, 8'h12, 1, 0, 0, 0, 0, "R11");
    rreg(0, "R11"); rreg(1, "R11"); rreg(0, "R11");
    wreg(3, 8'h03); rreg(1, "R11"); rreg(0, "R11"); rreg(5, "R11"); rreg(3, "R11");
    idle(); idle();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule